// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes on a single serial line in asynchronous frames. One word can wait in a holding register while another is shifted out, so a processor can write the next byte as soon as the previous one has moved into the shifter. When the holding register is refilled in time, frames follow each other with no idle bit time between them.

Software writes three registers through a small write port. The data register loads the holding buffer. The control register holds the enables, the optional ninth data bit and the high-speed select. The divisor register sets the bit rate. Two status outputs report whether the holding buffer and the shifter are empty. An interrupt request follows the buffer-empty flag when it is enabled.

Register addresses on `wr_addr` are 0 for data, 1 for control and 2 for divisor. The control bits are bit 0 transmit enable, bit 1 port enable, bit 2 ninth-bit enable, bit 3 ninth-bit value, bit 4 high-speed select and bit 5 interrupt enable. Bits 7:6 are spare.

Top module: `dbuf_serial_tx`

## Requirements
- R1: A frame is a low start bit, then the eight data bits least-significant first, then a high stop bit. The line idles high.
- R2: When control bit 2 is set, a ninth bit is sent between the data and the stop bit, with the value of control bit 3, giving an 11-bit frame. Otherwise the frame has 10 bits.
- R3: Each bit lasts 16×(divisor+1) clocks when control bit 4 is set, and 64×(divisor+1) clocks when it is clear. The divisor is written at address 2.
- R4: A data write (address 0) while enabled clears `hold_empty` from the next cycle. If the shifter is idle, the word moves to it one cycle later. In that cycle `hold_empty` sets again, `shift_empty` clears and the start bit begins.
- R5: A word that is waiting when a stop bit ends starts its start bit in the very next clock, with no idle time between the frames.
- R6: `shift_empty` stays low for the whole frame. It rises in the first cycle after the stop bit ends, and only if no word is waiting.
- R7: The block is enabled only when control bits 0 and 1 are both set. While it is disabled the line is high, data writes are discarded and both flags read as set. Disabling the block during a frame aborts the frame and drops any queued word.
- R8: `irq` is high exactly when `hold_empty` is high and control bit 5 is set.
- R9: After reset the line is high, both flags are set, `irq` is low, and the control and divisor registers are zero. The block is therefore disabled, and the divisor is 0 until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 control, 2 divisor |
| wr_data | input | 8 | Write data |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding buffer empty flag |
| shift_empty | output | 1 | Shift register empty flag |
| irq | output | 1 | Transmit interrupt request |

## Verification
The line is sampled every clock and compared with an expected waveform, so errors in bit order, frame length and bit-period length all show up as cycle-exact mismatches.

The frames are tried with four kinds of input:
- Alternating, all-ones and all-zeros data, which catch a wrong bit order and a stuck line.
- Ninth-bit frames with a value of 0 and of 1, which show whether that bit is inserted and where its value comes from.
- Both speed selects and more than one divisor, which tell the two period multipliers apart and catch an off-by-one in the divisor.
- A second word queued during the first frame, which tells a gapless hand-over from one that inserts an idle bit or drops the word.

Disabled-mode writes, an abort during a frame and the interrupt gating are checked at the flags and at the line.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DIV_W  = 8;

  localparam logic [ADDR_W-1:0] REG_HOLD = 2'd0;
  localparam logic [ADDR_W-1:0] REG_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] REG_DIV  = 2'd2;

  // Control byte, bit 0 is tx_en
  typedef struct packed {
    logic [1:0] spare;
    logic       irq_en;
    logic       fast;
    logic       nine_val;
    logic       nine_en;
    logic       port_en;
    logic       tx_en;
  } ctrl_t;
endpackage

// File: rtl/dbtx_regs.sv
module dbtx_regs
  import dbtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              active,
  input  logic              load,
  output ctrl_t             ctrl,
  output logic [DIV_W-1:0]  divisor,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full,
  output logic              data_wr
);
  assign data_wr = wr_en && (wr_addr == REG_HOLD) && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      divisor   <= '0;
      hold_data <= '0;
      hold_full <= 1'b0;
    end else begin
      if (wr_en && wr_addr == REG_CTRL) ctrl <= ctrl_t'(wr_data);
      if (wr_en && wr_addr == REG_DIV)  divisor <= wr_data[DIV_W-1:0];
      if (data_wr) hold_data <= wr_data[DATA_W-1:0];
      hold_full <= active && (data_wr || (hold_full && !load));
    end
  end
endmodule

// File: rtl/dbtx_baud.sv
module dbtx_baud #(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned FAST_SHIFT = 4,
  parameter int unsigned SLOW_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  input  logic             fast,
  output logic             tick
);
  localparam int unsigned CNT_W = DIV_W + SLOW_SHIFT;

  function automatic logic [CNT_W-1:0] period_m1(input logic [DIV_W-1:0] d, input logic f);
    logic [CNT_W:0] p;
    p = {{(CNT_W+1-DIV_W){1'b0}}, d} + {{CNT_W{1'b0}}, 1'b1};
    p = f ? (p << FAST_SHIFT) : (p << SLOW_SHIFT);
    p = p - {{CNT_W{1'b0}}, 1'b1};
    return p[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;

  assign reload = period_m1(divisor, fast);
  assign tick   = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= reload;
    else if (run)     cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end
endmodule

// File: rtl/dbtx_shifter.sv
module dbtx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              nine_en,
  input  logic              nine_val,
  input  logic              tick,
  output logic              load,
  output logic              frame_end,
  output logic              busy,
  output logic              txd
);
  localparam int unsigned FRAME_MAX = DATA_W + 3;
  localparam int unsigned BCNT_W    = $clog2(FRAME_MAX + 1);

  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                       input logic en9, input logic v9);
    return {1'b1, (en9 ? v9 : 1'b1), d, 1'b0};
  endfunction

  logic [FRAME_MAX-1:0] shreg;
  logic [BCNT_W-1:0]    bits_left;

  assign frame_end = busy && tick && (bits_left == BCNT_W'(1));
  assign load      = active && hold_full && (!busy || frame_end);
  assign txd       = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
    end else if (!active) begin
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
    end else if (load) begin
      busy      <= 1'b1;
      shreg     <= build_frame(hold_data, nine_en, nine_val);
      bits_left <= nine_en ? BCNT_W'(FRAME_MAX) : BCNT_W'(FRAME_MAX - 1);
    end else if (frame_end) begin
      busy      <= 1'b0;
      bits_left <= '0;
    end else if (busy && tick) begin
      shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
      bits_left <= bits_left - 1'b1;
    end
  end
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import dbtx_pkg::*;
#(
  parameter int unsigned FAST_SHIFT = 4,
  parameter int unsigned SLOW_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              irq
);
  ctrl_t             ctrl;
  logic [DIV_W-1:0]  divisor;
  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              data_wr;
  logic              load;
  logic              frame_end;
  logic              busy;
  logic              tick;
  logic              active;
  logic              unused_spare;

  assign active       = ctrl.tx_en && ctrl.port_en;
  assign unused_spare = ^ctrl.spare;

  dbtx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .active(active), .load(load), .ctrl(ctrl), .divisor(divisor),
    .hold_data(hold_data), .hold_full(hold_full), .data_wr(data_wr)
  );

  dbtx_baud #(.DIV_W(DIV_W), .FAST_SHIFT(FAST_SHIFT), .SLOW_SHIFT(SLOW_SHIFT)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(load),
    .divisor(divisor), .fast(ctrl.fast), .tick(tick)
  );

  dbtx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(active), .hold_full(hold_full),
    .hold_data(hold_data), .nine_en(ctrl.nine_en), .nine_val(ctrl.nine_val),
    .tick(tick), .load(load), .frame_end(frame_end), .busy(busy), .txd(txd)
  );

  assign hold_empty  = !hold_full || !active;
  assign shift_empty = !busy || !active;
  assign irq         = hold_empty && ctrl.irq_en;
endmodule

// File: rtl/dbtx_checker.sv
module dbtx_checker (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic data_wr,
  input logic load,
  input logic frame_end,
  input logic txd,
  input logic hold_empty,
  input logic shift_empty,
  input logic irq
);
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> txd);

  a_r4_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !hold_empty);

  a_r4_start_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);

  a_r4_buffer_refills: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !data_wr) |=> hold_empty);

  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !hold_empty) |=> !txd);

  a_r6_empty_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(shift_empty) && active && $past(active)) |-> $past(hold_empty));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> hold_empty);
endmodule

bind dbuf_serial_tx dbtx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .data_wr(data_wr), .load(load),
  .frame_end(frame_end), .txd(txd), .hold_empty(hold_empty),
  .shift_empty(shift_empty), .irq(irq)
);

// File: tb/test_dbuf_serial_tx.sv
module test_dbuf_serial_tx;
  import dbtx_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       txd, hold_empty, shift_empty, irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbuf_serial_tx i_dbuf_serial_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
  );

  // data, ninth enable, ninth value, fast, divisor
  localparam logic [18:0] VEC [5] = '{
    {8'hA5, 1'b0, 1'b0, 1'b1, 8'd0},
    {8'h3C, 1'b1, 1'b1, 1'b1, 8'd1},
    {8'hFF, 1'b1, 1'b0, 1'b1, 8'd0},
    {8'h00, 1'b0, 1'b0, 1'b0, 8'd0},
    {8'h81, 1'b1, 1'b1, 1'b0, 8'd1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [10:0] frame_bits(input logic [7:0] d, input bit nen, input bit nval);
    logic [10:0] f;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    if (nen) f[9] = nval;
    return f;
  endfunction

  // Entered at the negedge that is line index j0 (index 0 = first cycle of start bit)
  task automatic watch_line(input logic [21:0] bits, input int total, input int p,
                            input int j0, input string req);
    int errs = 0;
    for (int j = j0; j < total * p; j++) begin
      if (j != j0) @(negedge clk);
      if (txd !== bits[j / p]) begin
        if (errs == 0)
          $display("FAIL %s line at cycle %0d: got %0d expected %0d", req, j, txd, bits[j / p]);
        errs++;
      end
    end
    checks++;
    if (errs != 0) failures++;
    chk("R6", "shift_empty in last cycle of stop bit", int'(shift_empty), 0);
    @(negedge clk);
    chk("R6", "shift_empty after stop bit", int'(shift_empty), 1);
    chk("R1", "line idle after frame", int'(txd), 1);
  endtask

  task automatic hold_high(input int n, input string req);
    int errs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) errs++;
    end
    chk(req, "line held high, low samples", errs, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, dv;
    bit nen, nval, fast;
    int p, n;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9", "txd after reset", int'(txd), 1);
    chk("R9", "hold_empty after reset", int'(hold_empty), 1);
    chk("R9", "shift_empty after reset", int'(shift_empty), 1);
    chk("R9", "irq after reset", int'(irq), 0);
    bus_write(REG_HOLD, 8'h5A);
    chk("R9", "hold_empty with zero control", int'(hold_empty), 1);
    hold_high(30, "R9");

    // R9 divisor resets to zero: fast mode gives 16-clock bits
    bus_write(REG_CTRL, 8'h13);
    bus_write(REG_HOLD, 8'h96);
    @(negedge clk);
    watch_line({11'h7FF, frame_bits(8'h96, 1'b0, 1'b0)}, 10, 16, 0, "R9");

    // Table of frames: R1, R2, R3, R4
    for (int v = 0; v < 5; v++) begin
      d = VEC[v][18:11]; nen = VEC[v][10]; nval = VEC[v][9];
      fast = VEC[v][8]; dv = VEC[v][7:0];
      p = (fast ? 16 : 64) * (int'(dv) + 1);
      n = nen ? 11 : 10;
      bus_write(REG_CTRL, {2'b00, 1'b0, fast, nval, nen, 1'b1, 1'b1});
      bus_write(REG_DIV, dv);
      bus_write(REG_HOLD, d);
      chk("R4", "hold_empty after data write", int'(hold_empty), 0);
      chk("R4", "line still idle before transfer", int'(txd), 1);
      @(negedge clk);
      chk("R4", "start bit after transfer", int'(txd), 0);
      chk("R4", "hold_empty after transfer", int'(hold_empty), 1);
      chk("R4", "shift_empty after transfer", int'(shift_empty), 0);
      watch_line({11'h7FF, frame_bits(d, nen, nval)}, n, p, 0,
                 nen ? "R2" : (fast ? "R1" : "R3"));
    end

    // R5 back-to-back frames
    bus_write(REG_CTRL, 8'h13);
    bus_write(REG_DIV, 8'd0);
    bus_write(REG_HOLD, 8'h4D);
    bus_write(REG_HOLD, 8'hB2);
    chk("R5", "second word queued", int'(hold_empty), 0);
    chk("R5", "first frame start bit", int'(txd), 0);
    watch_line({2'b11, frame_bits(8'hB2, 1'b0, 1'b0)[9:0], frame_bits(8'h4D, 1'b0, 1'b0)[9:0]},
               20, 16, 1, "R5");

    // R8 interrupt gating
    chk("R8", "irq low with enable clear", int'(irq), 0);
    bus_write(REG_CTRL, 8'h33);
    chk("R8", "irq high when buffer empty", int'(irq), 1);
    bus_write(REG_HOLD, 8'hC3);
    chk("R8", "irq low after data write", int'(irq), 0);
    @(negedge clk);
    chk("R8", "irq high after transfer", int'(irq), 1);
    watch_line({11'h7FF, frame_bits(8'hC3, 1'b0, 1'b0)}, 10, 16, 0, "R8");
    bus_write(REG_CTRL, 8'h13);
    chk("R8", "irq low after enable cleared", int'(irq), 0);

    // R7 disabled modes and abort
    bus_write(REG_CTRL, 8'h11);
    bus_write(REG_HOLD, 8'h00);
    chk("R7", "hold_empty with port off", int'(hold_empty), 1);
    chk("R7", "shift_empty with port off", int'(shift_empty), 1);
    hold_high(40, "R7");
    bus_write(REG_CTRL, 8'h12);
    bus_write(REG_HOLD, 8'h00);
    chk("R7", "hold_empty with tx off", int'(hold_empty), 1);
    hold_high(40, "R7");
    bus_write(REG_CTRL, 8'h13);
    bus_write(REG_HOLD, 8'h00);
    repeat (20) @(negedge clk);
    chk("R7", "frame running before abort", int'(txd), 0);
    bus_write(REG_CTRL, 8'h12);
    chk("R7", "hold_empty after abort", int'(hold_empty), 1);
    chk("R7", "shift_empty after abort", int'(shift_empty), 1);
    @(negedge clk);
    chk("R7", "line high after abort", int'(txd), 1);
    bus_write(REG_CTRL, 8'h13);
    hold_high(200, "R7");
    chk("R7", "flags after re-enable", int'(hold_empty && shift_empty), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule